// File: doc/BRIEF.md
# Rotating-Priority Round-Robin Arbiter

This block shares one resource among a parameterised number of requesters. Each clock it looks at the request vector and a one-hot rotation pointer. It picks one requester: the first active request found at the pointer position or above it. If no request is active at or above the pointer, the search wraps around and goes on upward from position 0. The chosen grant is registered, so the one-hot grant output shows up one clock after the requests were sampled, and it is free of glitches.

The pointer has no clock enable. It is fed back through gating that keeps it while no grant is issued. In the cycle a grant is issued, the gating clears it and loads the position just above the winner. A requester that holds its request is therefore served within N grants. Two selection circuits can be chosen by parameter. One is a double-width borrow search. The other is a mask-then-lowest-bit search. Both give the same grant.

Top module: `rotor_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle.
- R2: A bit of `grant_o` is high only if the same bit of `req_i` was high in the cycle before.
- R3: `grant_o` is all zeros in the cycle after `req_i` was all zeros. It is nonzero in the cycle after any bit of `req_i` was high.
- R4: The granted position is the lowest active request index greater than or equal to the pointer position. If there is no such index, it is the lowest active request index overall. Bit i of `req_i` and `grant_o` belongs to requester i.
- R5: After a grant to requester i, the pointer moves to position (i+1) mod N. In a cycle with no grant, the pointer keeps its position.
- R6: `grant_o` changes only at a rising clock edge. It reflects the requests sampled at that edge, which gives one cycle of latency.
- R7: A synchronous active-high `rst` clears `grant_o` to zero and puts the pointer at position 0. This holds even while requests are active during reset.
- R8: With all requests held high, N consecutive cycles give each requester exactly one grant.
- R9: Rules R1 to R5 hold for a non-power-of-two requester count such as 3. They also hold for either selection circuit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_REQ | Request vector, bit i from requester i |
| grant_o | output | N_REQ | Registered one-hot (or zero) grant vector |

## Verification
The clocked properties assume that `req_i` is settled and free of X at every rising edge once reset is released. They also assume `rst` is held for at least one edge before the first check. The bench meets this by driving the requests only on falling edges. It asserts reset from time zero with all requests low, and it changes inputs only through its step task. The assertions place no limit on request patterns. For that reason the random phase draws any value of the request vector, including all-zero and all-one.

// File: rtl/rotor_arb_pkg.sv
package rotor_arb_pkg;
  typedef enum logic {
    SEL_BORROW = 1'b0,
    SEL_MASK   = 1'b1
  } sel_style_e;
endpackage

// File: rtl/rotor_select.sv
module rotor_select
  import rotor_arb_pkg::*;
#(
  parameter int         N     = 4,
  parameter sel_style_e STYLE = SEL_BORROW
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] ptr_i,
  output logic [N-1:0] win_o
);
  localparam int W2 = 2 * N;

  generate
    if (STYLE == SEL_BORROW) begin : g_borrow
      // Two copies of the requests, stacked; subtracting the one-hot pointer
      // borrows upward to the first set request, wrapping via the upper copy.
      logic [W2-1:0] stacked, borrowed, found;
      always_comb begin
        stacked  = {req_i, req_i};
        borrowed = stacked - {{N{1'b0}}, ptr_i};
        found    = stacked & ~borrowed;
      end
      assign win_o = found[N-1:0] | found[W2-1:N];
    end else begin : g_mask
      // Keep requests at or above the pointer; fall back to all requests.
      logic [N-1:0] upper, src, twos;
      always_comb begin
        upper = req_i & ~(ptr_i - {{(N-1){1'b0}}, 1'b1});
        src   = (|upper) ? upper : req_i;
        twos  = ~src + {{(N-1){1'b0}}, 1'b1};
      end
      assign win_o = src & twos;
    end
  endgenerate
endmodule

// File: rtl/rotor_pointer.sv
module rotor_pointer #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] win_i,
  output logic [N-1:0] ptr_o
);
  localparam logic [N-1:0] PTR_RESET = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] ptr_q, ptr_d, stepped;
  logic         any_win;

  always_comb begin
    any_win = |win_i;
    stepped = {win_i[N-2:0], win_i[N-1]};
    // Held through feedback gating; the gate opens only when a grant occurs.
    ptr_d   = (ptr_q & {N{~any_win}}) | stepped;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= PTR_RESET;
    else     ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R5: pointer stays one-hot
  assert_ptr_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot(ptr_q));
  // R5: no grant leaves the pointer where it was
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (win_i == '0) |=> $stable(ptr_q));
  // R5: after a grant the pointer no longer sits on the winner
  assert_ptr_leaves_R5: assert property (@(posedge clk) disable iff (rst)
    (win_i != '0) |=> ((ptr_q & $past(win_i)) == '0));
  // R7: reset puts the pointer at position 0
  assert_ptr_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_q == PTR_RESET));
endmodule

// File: rtl/rotor_arbiter.sv
module rotor_arbiter
  import rotor_arb_pkg::*;
#(
  parameter int         N_REQ = 4,
  parameter sel_style_e STYLE = SEL_BORROW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] grant_o
);
  logic [N_REQ-1:0] ptr, win, grant_q;

  rotor_select #(.N(N_REQ), .STYLE(STYLE)) u_select (
    .req_i (req_i),
    .ptr_i (ptr),
    .win_o (win)
  );

  rotor_pointer #(.N(N_REQ)) u_pointer (
    .clk   (clk),
    .rst   (rst),
    .win_i (win),
    .ptr_o (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) grant_q <= '0;
    else     grant_q <= win;
  end

  assign grant_o = grant_q;

  // R1: never more than one grant
  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));
  // R2: grant only to a requester that asked
  assert_granted_req_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((grant_q & ~$past(req_i)) == '0));
  // R3: idle requests give no grant
  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i == '0) |=> (grant_q == '0));
  // R3: any request is served
  assert_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i != '0) |=> (grant_q != '0));
  // R7: grant cleared by reset
  assert_grant_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (grant_q == '0));
endmodule

// File: tb/rotor_arbiter_test.sv
module rotor_arbiter_test;
  import rotor_arb_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req4 = '0;
  logic [2:0] req3 = '0;
  logic [3:0] g4;
  logic [2:0] g3;

  int total = 0;
  int bad   = 0;
  int p4 = 0;
  int p3 = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotor_arbiter #(.N_REQ(4), .STYLE(SEL_BORROW)) uut (
    .clk(clk), .rst(rst), .req_i(req4), .grant_o(g4));

  rotor_arbiter #(.N_REQ(3), .STYLE(SEL_MASK)) uut3 (
    .clk(clk), .rst(rst), .req_i(req3), .grant_o(g3));

  // {req[3:0], expected grant[3:0]} from reset, pointer at 0 (R4, R5)
  localparam logic [7:0] VEC [10] = '{
    8'b1111_0001, 8'b1111_0010, 8'b0001_0001, 8'b0000_0000, 8'b1001_1000,
    8'b1001_0001, 8'b0110_0010, 8'b0110_0100, 8'b0011_0001, 8'b1000_1000
  };

  function automatic int pick(int n, logic [7:0] r, int p);
    for (int k = 0; k < n; k++) begin
      int i;
      i = (p + k) % n;
      if (r[i]) return i;
    end
    return -1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(logic [3:0] r4, logic [2:0] r3, string tag);
    int i4, i3;
    logic [3:0] e4, o4;
    logic [2:0] e3, o3;
    i4 = pick(4, {4'b0, r4}, p4);
    i3 = pick(3, {5'b0, r3}, p3);
    e4 = (i4 < 0) ? 4'b0 : 4'(1 << i4);
    e3 = (i3 < 0) ? 3'b0 : 3'(1 << i3);
    o4 = g4;
    o3 = g3;
    req4 = r4;
    req3 = r3;
    #1;
    check("R6 grant held until edge", {4'b0, g4}, {4'b0, o4});
    check("R6 grant held until edge n3", {5'b0, g3}, {5'b0, o3});
    @(negedge clk);
    check({tag, " n4"}, {4'b0, g4}, {4'b0, e4});
    check({"R9 ", tag, " n3"}, {5'b0, g3}, {5'b0, e3});
    if (i4 >= 0) p4 = (i4 + 1) % 4;
    if (i3 >= 0) p3 = (i3 + 1) % 3;
  endtask

  task automatic do_reset(logic [3:0] r4, logic [2:0] r3);
    rst = 1'b1;
    req4 = r4;
    req3 = r3;
    @(negedge clk);
    @(negedge clk);
    check("R7 grant cleared n4", {4'b0, g4}, 8'b0);
    check("R7 grant cleared n3", {5'b0, g3}, 8'b0);
    rst = 1'b0;
    p4 = 0;
    p3 = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] seen;
    @(negedge clk);
    do_reset(4'b0, 3'b0);

    // table walk (R4, R5, R3)
    for (int v = 0; v < 10; v++) begin
      step(VEC[v][7:4], 3'b0, "R4 table");
      check("R4 R5 table vector", {4'b0, g4}, {4'b0, VEC[v][3:0]});
    end

    // move pointer away from 0, then reset with requests active (R7)
    step(4'b0100, 3'b010, "R5 park pointer");
    do_reset(4'b1111, 3'b111);
    step(4'b1111, 3'b111, "R7 pointer back at 0");
    check("R7 first grant after reset", {4'b0, g4}, 8'b0000_0001);

    // fairness with all requests held (R8)
    seen = '0;
    for (int c = 0; c < 4; c++) begin
      step(4'b1111, 3'b111, "R8 hold all");
      check("R8 single new grant", {4'b0, (g4 & seen)}, 8'b0);
      seen = seen | g4;
    end
    check("R8 all served", {4'b0, seen}, 8'b0000_1111);

    // wrap from top pointer (R4), idle hold (R5)
    step(4'b1000, 3'b100, "R4 top");
    step(4'b0000, 3'b000, "R3 idle");
    step(4'b0110, 3'b011, "R5 hold then wrap");

    // random patterns, model based (R1 R2 R4 R9)
    for (int n = 0; n < 400; n++) begin
      step(4'($urandom % 16), 3'($urandom % 8), "R4 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule